// File: doc/BRIEF.md
# Data Translation Lookup Unit

This block translates the virtual address of a data access into a physical address using a small, fully associative set of translation entries. Each request presents a 32-bit virtual address, the current process ID, an access kind (load, store or data-cache flush) and the exception-handling status bit. One cycle later the block returns a response strobe, and with it either a physical address or a 2-bit exception code.

An entry matches when it is valid, its 20-bit virtual page number equals bits [31:12] of the request address, and it is either marked global or carries the request's process ID. When several entries match, the one with the lowest index is used. A load needs the entry's read permission and a store needs its write permission. A flush that matches is never refused. A permitted access forms its physical address from the entry's frame number and the 12-bit page offset. A request that matches no entry raises one of two miss codes, chosen by the status bit.

Entries are loaded through a write port that takes an index and a complete entry. Software or a miss handler uses this port to install or remove translations. Choosing a victim slot is left to the caller.

Top module: `dtlb_lookup`

## Requirements
- R1: While reset (rst_n low, synchronous) is applied, and after it, rsp_valid is 0 and every entry is invalid, so the first lookup after reset misses.
- R2: An entry matches a request only when its valid bit is 1, its page number equals vaddr[31:12], and either its global bit is 1 or its process ID equals req_pid.
- R3: On a match, a load without the read bit and a store without the write bit give rsp_exc = 2'b01 (permission violation) and rsp_paddr = 0.
- R4: A flush (req_kind = 2'b10) that matches gives rsp_exc = 2'b00 with the translated address, whatever the read and write bits hold.
- R5: A permitted match gives rsp_exc = 2'b00 and rsp_paddr = {frame number, vaddr[11:0]}.
- R6: A request that matches no entry gives rsp_exc = 2'b11 when req_eh is 1 and rsp_exc = 2'b10 when req_eh is 0, with rsp_paddr = 0.
- R7: rsp_valid is 1 exactly in the cycle after a cycle with req_valid = 1. When rsp_valid is 0, rsp_exc and rsp_paddr are 0.
- R8: When more than one entry matches, the entry with the lowest index supplies the permissions and the frame number.
- R9: A write takes effect for requests issued in the cycle after it. A request issued in the same cycle as a write sees the previous contents of the array.
- R10: Access kinds are encoded as 2'b00 load, 2'b01 store and 2'b10 flush. The code 2'b11 is checked as a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address of the access |
| req_pid | input | 8 | Current process ID |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 flush, 11 treated as load |
| req_eh | input | 1 | Exception-handling status bit; selects the miss code |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | 4 | Index of the entry to write |
| wr_valid | input | 1 | Valid bit of the new entry |
| wr_vpn | input | 20 | Virtual page number of the new entry |
| wr_pid | input | 8 | Process ID of the new entry |
| wr_global | input | 1 | Global bit of the new entry |
| wr_read | input | 1 | Read permission of the new entry |
| wr_write | input | 1 | Write permission of the new entry |
| wr_pfn | input | 20 | Physical frame number of the new entry |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 32 | Physical address; 0 unless the access is permitted |
| rsp_exc | output | 2 | 00 none, 01 permission, 10 fast miss, 11 double miss |

## Verification
The bench runs each access kind against entries whose read and write bits are set to each value. This separates the permission cases of loads, stores, flushes and the reserved kind. Two requests share a page number but differ in process ID, once against a global entry and once against a private one, which isolates the process-ID bypass. Misses are issued with both values of the status bit. A request placed in the same cycle as a write, and then repeated one cycle later, pins down when a write becomes visible. Duplicate entries at two indices expose the match priority. A long random stream over a small pool of page numbers and process IDs mixes all of these cases, and the behavioural model is compared with the outputs on every cycle.

// File: rtl/dtlb_pkg.sv
// Shared types for the data translation lookup unit.
// Assumes 4 KB pages: 20-bit page and frame numbers over a 32-bit address.
package dtlb_pkg;
    localparam int VPN_W  = 20;
    localparam int PFN_W  = 20;
    localparam int PID_W  = 8;
    localparam int OFS_W  = 12;
    localparam int VA_W   = VPN_W + OFS_W;
    localparam int PA_W   = PFN_W + OFS_W;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FLUSH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'b00,
        EXC_PERM  = 2'b01,
        EXC_FMISS = 2'b10,
        EXC_DMISS = 2'b11
    } exc_code_e;

    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] vpn;
        logic [PID_W-1:0] pid;
        logic             glob;
        logic             rd;
        logic             wr;
        logic [PFN_W-1:0] pfn;
    } xlat_entry_t;
endpackage

// File: rtl/dtlb_store.sv
// Entry storage: ENTRIES registered translation entries with one write port.
// Assumes wr_idx < ENTRIES. The write lands at the clock edge, so lookups read
// the new contents from the next cycle on. Reset clears every valid bit.
module dtlb_store
    import dtlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          widx,
    input  xlat_entry_t               wdata,
    output xlat_entry_t [ENTRIES-1:0] ents
);
    xlat_entry_t [ENTRIES-1:0] mem_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Purpose: hold one entry; clear its valid bit on reset, load on a write hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                mem_q[g] <= wdata;
            end
        end
    end

    assign ents = mem_q;
endmodule

// File: rtl/dtlb_match.sv
// Parallel compare of all entries against a page number and process ID,
// followed by a lowest-index-first select. Assumes entries are stable in the cycle.
module dtlb_match
    import dtlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  xlat_entry_t [ENTRIES-1:0] ents,
    input  logic [VPN_W-1:0]          vpn,
    input  logic [PID_W-1:0]          pid,
    output logic                      hit,
    output xlat_entry_t               sel
);
    logic [ENTRIES-1:0] match_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = ents[g].vld && (ents[g].vpn == vpn)
                              && (ents[g].glob || (ents[g].pid == pid));
    end

    // Purpose: pick the matching entry with the smallest index.
    always_comb begin
        hit = |match_vec;
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) sel = ents[i];
        end
    end
endmodule

// File: rtl/dtlb_judge.sv
// Permission check, address formation and exception classification for one
// selected entry. Assumes sel is meaningful only when hit is 1.
module dtlb_judge
    import dtlb_pkg::*;
(
    input  logic             hit,
    input  xlat_entry_t      sel,
    input  acc_kind_e        kind,
    input  logic             eh,
    input  logic [OFS_W-1:0] ofs,
    output exc_code_e        exc,
    output logic [PA_W-1:0]  paddr
);
    logic allowed;

    // Purpose: decide whether the access kind is allowed by the entry.
    always_comb begin
        unique case (kind)
            ACC_FLUSH: allowed = 1'b1;
            ACC_STORE: allowed = sel.wr;
            default:   allowed = sel.rd;
        endcase
    end

    // Purpose: classify the outcome and form the physical address.
    always_comb begin
        paddr = '0;
        if (!hit) begin
            exc = eh ? EXC_DMISS : EXC_FMISS;
        end else if (!allowed) begin
            exc = EXC_PERM;
        end else begin
            exc   = EXC_NONE;
            paddr = {sel.pfn, ofs};
        end
    end
endmodule

// File: rtl/dtlb_lookup.sv
// Top of the data translation lookup unit. A request is evaluated against the
// array in the cycle it is presented; the result is registered and appears
// with rsp_valid one cycle later. Assumes ENTRIES is a power of two.
module dtlb_lookup
    import dtlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [PID_W-1:0]   req_pid,
    input  logic [1:0]         req_kind,
    input  logic               req_eh,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_valid,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PID_W-1:0]   wr_pid,
    input  logic               wr_global,
    input  logic               wr_read,
    input  logic               wr_write,
    input  logic [PFN_W-1:0]   wr_pfn,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [1:0]         rsp_exc
);
    xlat_entry_t                wentry;
    xlat_entry_t [ENTRIES-1:0]  ents;
    xlat_entry_t                sel;
    logic                       hit;
    exc_code_e                  exc_d;
    logic [PA_W-1:0]            paddr_d;

    assign wentry = '{vld: wr_valid, vpn: wr_vpn, pid: wr_pid, glob: wr_global,
                      rd: wr_read, wr: wr_write, pfn: wr_pfn};

    dtlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .widx  (wr_idx),
        .wdata (wentry),
        .ents  (ents)
    );

    dtlb_match #(.ENTRIES(ENTRIES)) u_match (
        .ents (ents),
        .vpn  (req_vaddr[VA_W-1:OFS_W]),
        .pid  (req_pid),
        .hit  (hit),
        .sel  (sel)
    );

    dtlb_judge u_judge (
        .hit   (hit),
        .sel   (sel),
        .kind  (acc_kind_e'(req_kind)),
        .eh    (req_eh),
        .ofs   (req_vaddr[OFS_W-1:0]),
        .exc   (exc_d),
        .paddr (paddr_d)
    );

    // Purpose: register the response; quiet outputs when no request was taken.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_exc   <= EXC_NONE;
        end else begin
            rsp_valid <= 1'b1;
            rsp_paddr <= paddr_d;
            rsp_exc   <= exc_d;
        end
    end
endmodule

// File: rtl/dtlb_lookup_chk.sv
// Checker for dtlb_lookup, bound to every instance. It keeps its own copy of
// the previous request, so no property reaches back past reset.
module dtlb_lookup_chk
    import dtlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic [1:0]       req_kind,
    input logic             req_eh,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [1:0]       rsp_exc
);
    logic             q_req;
    logic             q_eh;
    logic [1:0]       q_kind;
    logic [OFS_W-1:0] q_ofs;

    // Purpose: remember the request taken at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_req  <= 1'b0;
            q_eh   <= 1'b0;
            q_kind <= 2'b00;
            q_ofs  <= '0;
        end else begin
            q_req  <= req_valid;
            q_eh   <= req_eh;
            q_kind <= req_kind;
            q_ofs  <= req_vaddr[OFS_W-1:0];
        end
    end

    AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == q_req); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_exc == 2'b00 && rsp_paddr == '0)); // R7
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc != 2'b00) |-> rsp_paddr == '0); // R3
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc == 2'b00) |-> rsp_paddr[OFS_W-1:0] == q_ofs); // R5
    AST_MISS_BY_EH: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc[1]) |-> rsp_exc[0] == q_eh); // R6
    AST_FLUSH_NEVER_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && q_kind == 2'b10) |-> rsp_exc != 2'b01); // R4
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid); // R1
endmodule

bind dtlb_lookup dtlb_lookup_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .req_kind  (req_kind),
    .req_eh    (req_eh),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_exc   (rsp_exc)
);

// File: tb/test_dtlb_lookup.sv
// Bench for dtlb_lookup: a behavioural model kept in plain arrays predicts
// every response, and the outputs are compared on every cycle.
module test_dtlb_lookup;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_pid = '0;
    logic [1:0]  req_kind = '0;
    logic        req_eh = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [19:0] wr_vpn = '0;
    logic [7:0]  wr_pid = '0;
    logic        wr_global = 1'b0;
    logic        wr_read = 1'b0;
    logic        wr_write = 1'b0;
    logic [19:0] wr_pfn = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_exc;

    int vectors = 0;
    int fails   = 0;

    // behavioural model of the array
    bit       m_vld [16];
    int       m_vpn [16];
    int       m_pid [16];
    bit       m_g   [16];
    bit       m_r   [16];
    bit       m_w   [16];
    int       m_pfn [16];

    always #5 clk = ~clk;

    dtlb_lookup i_dtlb_lookup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_pid(req_pid), .req_kind(req_kind), .req_eh(req_eh), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_vpn(wr_vpn), .wr_pid(wr_pid),
        .wr_global(wr_global), .wr_read(wr_read), .wr_write(wr_write),
        .wr_pfn(wr_pfn), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_exc(rsp_exc)
    );

    task automatic compare(input string tag, input logic ev, input logic [1:0] ee,
                           input logic [31:0] ep);
        vectors++;
        if (rsp_valid !== ev || rsp_exc !== ee || rsp_paddr !== ep) begin
            fails++;
            $display("FAIL %s: got valid=%0b exc=%0d paddr=%h, expected valid=%0b exc=%0d paddr=%h",
                     tag, rsp_valid, rsp_exc, rsp_paddr, ev, ee, ep);
        end
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] pid,
                          input logic [1:0] kind, input logic eh);
        req_valid = 1'b1; req_vaddr = va; req_pid = pid; req_kind = kind; req_eh = eh;
    endtask

    task automatic put(input int idx, input logic v, input logic [19:0] vpn,
                       input logic [7:0] pid, input logic g, input logic r,
                       input logic w, input logic [19:0] pfn);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_valid = v; wr_vpn = vpn; wr_pid = pid;
        wr_global = g; wr_read = r; wr_write = w; wr_pfn = pfn;
    endtask

    // Predict from the current inputs and model, apply the write, advance one
    // clock, compare at the following falling edge, then clear the strobes.
    task automatic tick(input string tag);
        logic        ev;
        logic [1:0]  ee;
        logic [31:0] ep;
        int          found;
        bit          ok;
        ev = req_valid; ee = 2'b00; ep = '0; found = -1;
        if (req_valid) begin
            for (int i = 0; i < 16; i++) begin
                if (found < 0 && m_vld[i] && m_vpn[i] == int'(req_vaddr[31:12])
                    && (m_g[i] || m_pid[i] == int'(req_pid))) found = i;
            end
            if (found < 0) begin
                ee = req_eh ? 2'b11 : 2'b10;
            end else begin
                if (req_kind == 2'b10)      ok = 1'b1;
                else if (req_kind == 2'b01) ok = m_w[found];
                else                        ok = m_r[found];
                if (ok) ep = {20'(m_pfn[found]), req_vaddr[11:0]};
                else    ee = 2'b01;
            end
        end
        if (wr_en) begin
            m_vld[wr_idx] = wr_valid; m_vpn[wr_idx] = int'(wr_vpn);
            m_pid[wr_idx] = int'(wr_pid); m_g[wr_idx] = wr_global;
            m_r[wr_idx] = wr_read; m_w[wr_idx] = wr_write; m_pfn[wr_idx] = int'(wr_pfn);
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag, ev, ee, ep);
        req_valid = 1'b0;
        wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_vld[i] = 1'b0;
        // R1: reset holds the response low and clears the array
        repeat (3) @(negedge clk);
        compare("R1", 1'b0, 2'b00, 32'h0);
        rst_n = 1'b1;
        lookup(32'h0000_0123, 8'd0, 2'b00, 1'b0); tick("R1");
        lookup(32'h0000_0123, 8'd0, 2'b00, 1'b1); tick("R6");

        // R9: request in the same cycle as the write sees the old contents
        put(3, 1, 20'h12345, 8'd5, 0, 1, 0, 20'hABCDE);
        lookup(32'h1234_5678, 8'd5, 2'b00, 1'b0); tick("R9");
        lookup(32'h1234_5678, 8'd5, 2'b00, 1'b0); tick("R5");
        lookup(32'h1234_5FFF, 8'd5, 2'b01, 1'b1); tick("R3");
        lookup(32'h1234_5000, 8'd5, 2'b10, 1'b0); tick("R4");
        lookup(32'h1234_5678, 8'd6, 2'b00, 1'b1); tick("R2");
        tick("R7");

        // R2: global entry ignores the process ID
        put(4, 1, 20'h22222, 8'd9, 1, 0, 1, 20'h00042);
        tick("R9");
        lookup(32'h2222_2ABC, 8'd1, 2'b01, 1'b0); tick("R2");
        lookup(32'h2222_2ABC, 8'd1, 2'b00, 1'b0); tick("R3");
        lookup(32'h2222_2ABC, 8'd1, 2'b11, 1'b0); tick("R10");
        lookup(32'h2222_2ABC, 8'd7, 2'b10, 1'b0); tick("R4");

        // R8: duplicates at indices 7 and 2, the lower index wins
        put(7, 1, 20'h33333, 8'd2, 0, 1, 1, 20'h77777); tick("R8");
        put(2, 1, 20'h33333, 8'd2, 0, 1, 0, 20'h22222); tick("R8");
        lookup(32'h3333_3010, 8'd2, 2'b00, 1'b0); tick("R8");
        lookup(32'h3333_3010, 8'd2, 2'b01, 1'b0); tick("R8");

        // R2: clearing the valid bit removes the translation
        put(3, 0, 20'h12345, 8'd5, 0, 1, 1, 20'hABCDE);
        lookup(32'h1234_5678, 8'd5, 2'b00, 1'b0); tick("R9");
        lookup(32'h1234_5678, 8'd5, 2'b00, 1'b0); tick("R2");

        // mixed random stream over a small pool of pages and IDs
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 2) == 0)
                put(int'($urandom_range(0, 15)), 1'($urandom_range(0, 4) != 0),
                    20'($urandom_range(0, 5)), 8'($urandom_range(0, 3)),
                    1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), 20'($urandom));
            if ($urandom_range(0, 3) != 0)
                lookup({20'($urandom_range(0, 5)), 12'($urandom)},
                       8'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                       1'($urandom_range(0, 1)));
            tick("R5");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule